// File: doc/BRIEF.md
# Keyboard Matrix Scan Controller

The block scans a key matrix and a multiplexed digit display from one shared scan counter. The counter advances once every `PRESCALE` clock cycles. Its value goes out on four scan lines either as a plain binary count for an external decoder or as a one-hot pattern that drives four digits directly. The same count selects the keyboard row and the display digit, so keyboard and display always share one scan mode.

On a return line, a key closure starts a timed debounce. When that time is up, the key is tested again on the next visit to its row, and only a key that is still down is accepted. An accepted key becomes one code byte that also holds the shift and control inputs. Codes wait in an eight-entry FIFO until the host reads them, and the interrupt output stays high while any code is waiting. A sixteen-byte display memory is written through an address pointer that steps forward after every data write, and the memory feeds the segment outputs in step with the scan.

The host port has a single select bit. With the bit high it writes commands and reads status. With the bit low it writes display data and reads key codes.

Top module: `kbd_scan_ctrl`

## Requirements
- R1: In encoded mode (the mode after reset), `scan_o` carries a 4-bit binary count. The count rises by one every `PRESCALE` clock cycles and wraps from 15 to 0.
- R2: A command write of `8'b00xx_xxxm` sets the mode and restarts the scan at count 0. With m=1 (decoded mode), `scan_o` shows the one-hot code of count[1:0] (0001, 0010, 0100, 1000, repeating); with m=0 it is back in encoded mode.
- R3: The keyboard row is count[2:0] and is scanned only while count[3]=0, so encoded mode reaches rows 0-7 and decoded mode reaches rows 0-3. The key column is the lowest-numbered return line that is high.
- R4: A closure is accepted only if the same key is still down when its row is scanned again after `DEBOUNCE` cycles. A closure released before that stores nothing.
- R5: The stored code byte is {control, shift, row[2:0], column[2:0]}, with bit 7 as control. The shift and control levels are those present in the cycle the key is accepted.
- R6: A key that is held down is stored once. Another code is stored only after that key has been seen released.
- R7: The FIFO holds up to 8 codes and returns them in the order they were accepted.
- R8: `irq_o` is high while the FIFO holds at least one code and goes low once the last code has been read.
- R9: A key accepted while the FIFO is full is discarded and sets a sticky overflow flag. The flag is cleared by the command `8'b01xx_xxxx`.
- R10: The command `8'b1xxx_aaaa` loads display address a. Each data write stores the byte at the current address and then advances the address by one, wrapping from 15 to 0.
- R11: `seg_o` shows the display byte of the current digit. The digit is the count in encoded mode and count[1:0] in decoded mode.
- R12: A read with `host_cmd`=1 returns the status {overflow, full, 2'b00, fill count[3:0]}. A read with `host_cmd`=0 removes and returns the oldest code, or returns 8'h00 when the FIFO is empty. `host_rdata` is valid from the cycle after the read strobe and holds its value until the next read.
- R13: After reset the scan count is 0, the mode is encoded, the FIFO is empty, the overflow flag is clear, `irq_o` and `host_rdata` are 0, and every display byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_cmd | input | 1 | Port select: 1 = command/status, 0 = data |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| ret_i | input | 8 | Matrix return lines, high = key closed on the scanned row |
| shift_i | input | 1 | Shift key level |
| ctrl_i | input | 1 | Control key level |
| scan_o | output | 4 | Scan lines shared by keyboard and display |
| seg_o | output | 8 | Segment byte for the current digit |
| irq_o | output | 1 | Key codes waiting |

## Verification
The hardest case to reach is the overflow path. The FIFO has to be full at the moment a ninth key passes its debounce re-check, and that only happens after eight separate keys have each been pressed, held through the debounce and the row revisit, and released. The bench builds this with a model of the key matrix that answers the scan lines the way real switches would. It presses nine keys on different rows and columns one after another and reads nothing in between. It then checks the status byte, the order of the eight stored codes, the loss of the ninth, and the clearing command. A closure that bounces away during the debounce window is brought about the same way, with the key held just long enough to be seen once on its row.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  // Code byte layout: {ctrl, shift, row[2:0], col[2:0]}
  localparam int ROW_W  = 3;
  localparam int COL_W  = 3;
  localparam int RET_W  = 1 << COL_W;
  localparam int CODE_W = 2 + ROW_W + COL_W;
  localparam int SCAN_W = 4;
  localparam int DIGITS = 1 << SCAN_W;
  localparam int DEC_W  = 2;

  typedef enum logic [1:0] {
    DB_IDLE  = 2'd0,
    DB_WAIT  = 2'd1,
    DB_CHECK = 2'd2,
    DB_HELD  = 2'd3
  } db_state_e;
endpackage

// File: rtl/kbd_scan_timer.sv
module kbd_scan_timer
  import kbd_pkg::*;
#(
  parameter int PRESCALE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              decoded,
  output logic              tick,
  output logic [SCAN_W-1:0] cnt,
  output logic [SCAN_W-1:0] scan_o
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PS_W-1:0]   presc_q, presc_d;
  logic [SCAN_W-1:0] cnt_q, cnt_d;

  assign tick = (presc_q == PS_W'(PRESCALE - 1));

  always_comb begin
    presc_d = presc_q;
    cnt_d   = cnt_q;
    if (restart) begin
      presc_d = '0;
      cnt_d   = '0;
    end else if (tick) begin
      presc_d = '0;
      if (decoded) cnt_d = {{(SCAN_W-DEC_W){1'b0}}, cnt_q[DEC_W-1:0] + DEC_W'(1)};
      else         cnt_d = cnt_q + SCAN_W'(1);
    end else begin
      presc_d = presc_q + PS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else begin
      presc_q <= presc_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  always_comb begin
    if (decoded) scan_o = SCAN_W'(1) << cnt_q[DEC_W-1:0];
    else         scan_o = cnt_q;
  end

  // R1: binary count steps by one on each tick in encoded mode
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && !decoded) |=> (SCAN_W'(cnt_q - $past(cnt_q)) == SCAN_W'(1)));

  // R2: decoded mode keeps the count within the four-digit range
  p_dec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    decoded |-> (cnt_q[SCAN_W-1:DEC_W] == '0));
endmodule

// File: rtl/kbd_debounce.sv
module kbd_debounce
  import kbd_pkg::*;
#(
  parameter int DEBOUNCE = 1250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic             row_valid,
  input  logic [ROW_W-1:0] row,
  input  logic [RET_W-1:0] ret_i,
  output logic             key_push,
  output logic [ROW_W-1:0] key_row,
  output logic [COL_W-1:0] key_col
);
  localparam int DB_W = $clog2(DEBOUNCE + 1);

  db_state_e        st_q, st_d;
  logic [DB_W-1:0]  deb_q, deb_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [COL_W-1:0] first_col;
  logic             at_row;

  // lowest-numbered closed return line
  always_comb begin
    first_col = '0;
    for (int i = RET_W - 1; i >= 0; i--) begin
      if (ret_i[i]) first_col = COL_W'(i);
    end
  end

  assign at_row = tick && row_valid && (row == row_q);

  always_comb begin
    st_d     = st_q;
    deb_d    = deb_q;
    row_d    = row_q;
    col_d    = col_q;
    key_push = 1'b0;
    if (restart) begin
      st_d = DB_IDLE;
    end else begin
      unique case (st_q)
        DB_IDLE: begin
          if (tick && row_valid && (|ret_i)) begin
            st_d  = DB_WAIT;
            deb_d = DB_W'(DEBOUNCE);
            row_d = row;
            col_d = first_col;
          end
        end
        DB_WAIT: begin
          if (deb_q == '0) st_d  = DB_CHECK;
          else             deb_d = deb_q - DB_W'(1);
        end
        DB_CHECK: begin
          if (at_row) begin
            if (ret_i[col_q]) begin
              key_push = 1'b1;
              st_d     = DB_HELD;
            end else begin
              st_d = DB_IDLE;
            end
          end
        end
        DB_HELD: begin
          if (at_row && !ret_i[col_q]) st_d = DB_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DB_IDLE;
      deb_q <= '0;
      row_q <= '0;
      col_q <= '0;
    end else begin
      st_q  <= st_d;
      deb_q <= deb_d;
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign key_row = row_q;
  assign key_col = col_q;

  // R4: the re-check phase is entered only once the debounce count is spent
  p_check_after_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == DB_CHECK) |-> ($past(st_q) == DB_WAIT && $past(deb_q) == '0));

  // R6: one accepted key produces a single push
  p_single_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    key_push |=> !key_push);
endmodule

// File: rtl/kbd_key_fifo.sv
module kbd_key_fifo
  import kbd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [CODE_W-1:0]          din,
  input  logic                       pop,
  input  logic                       ovf_clr,
  output logic [CODE_W-1:0]          dout,
  output logic                       empty,
  output logic                       full,
  output logic                       ovf,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              do_push, do_pop;
  logic [CODE_W-1:0] slot_w [DEPTH];

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_d  = do_push ? ptr_inc(wr_q) : wr_q;
    rd_d  = do_pop  ? ptr_inc(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + CNT_W'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CNT_W'(1);
    ovf_d = ovf_q;
    if (ovf_clr)      ovf_d = 1'b0;
    if (push && full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [CODE_W-1:0] data_q;
    logic              we;
    assign we = do_push && (wr_q == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  data_q <= '0;
      else if (we) data_q <= din;
    end
    assign slot_w[g] = data_q;
  end

  assign dout  = slot_w[rd_q];
  assign ovf   = ovf_q;
  assign count = cnt_q;

  // R9: a push into a full FIFO leaves the fill level alone and flags overflow
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt_q == $past(cnt_q) && ovf_q));

  // R7: depth never exceeded
  p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R8: a pop with no push drops the fill level by one
  p_pop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/kbd_disp_ram.sv
module kbd_disp_ram
  import kbd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_addr,
  input  logic [SCAN_W-1:0] addr_in,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [SCAN_W-1:0] digit,
  output logic [BYTE_W-1:0] seg
);
  logic [SCAN_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] byte_w [DIGITS];

  always_comb begin
    addr_d = addr_q;
    if (set_addr) addr_d = addr_in;
    else if (wr)  addr_d = addr_q + SCAN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_byte
    logic [BYTE_W-1:0] data_q;
    logic              we;
    assign we = wr && (addr_q == SCAN_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  data_q <= '0;
      else if (we) data_q <= wdata;
    end
    assign byte_w[g] = data_q;
  end

  assign seg = byte_w[digit];

  // R10: every data write advances the display address by one
  p_autoinc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !set_addr) |=> (SCAN_W'(addr_q - $past(addr_q)) == SCAN_W'(1)));
endmodule

// File: rtl/kbd_scan_ctrl.sv
module kbd_scan_ctrl
  import kbd_pkg::*;
#(
  parameter int PRESCALE   = 64,
  parameter int DEBOUNCE   = 1250000,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cmd,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [RET_W-1:0]  ret_i,
  input  logic              shift_i,
  input  logic              ctrl_i,
  output logic [SCAN_W-1:0] scan_o,
  output logic [7:0]        seg_o,
  output logic              irq_o
);
  localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);

  logic              rst_s1_q, rst_s2_q, rst_int;
  logic              dec_q, dec_d;
  logic [7:0]        rdata_q, rdata_d;
  logic              cmd_wr, mode_wr, ovf_clr, addr_set, data_wr, pop;
  logic              tick, row_valid;
  logic [SCAN_W-1:0] cnt, digit;
  logic              key_push;
  logic [ROW_W-1:0]  key_row;
  logic [COL_W-1:0]  key_col;
  logic [CODE_W-1:0] key_code, head;
  logic              f_empty, f_full, f_ovf;
  logic [FCNT_W-1:0] f_count;
  logic [7:0]        status;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int = rst_s2_q;

  // host decode
  assign cmd_wr   = host_wr && host_cmd;
  assign mode_wr  = cmd_wr && (host_wdata[7:6] == 2'b00);
  assign ovf_clr  = cmd_wr && (host_wdata[7:6] == 2'b01);
  assign addr_set = cmd_wr && host_wdata[7];
  assign data_wr  = host_wr && !host_cmd;
  assign pop      = host_rd && !host_cmd && !f_empty;

  assign status = {f_ovf, f_full, {(6 - FCNT_W){1'b0}}, f_count};

  always_comb begin
    dec_d = dec_q;
    if (mode_wr) dec_d = host_wdata[0];
    rdata_d = rdata_q;
    if (host_rd) begin
      if (host_cmd)     rdata_d = status;
      else if (f_empty) rdata_d = '0;
      else              rdata_d = head;
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      dec_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      dec_q   <= dec_d;
      rdata_q <= rdata_d;
    end
  end

  kbd_scan_timer #(.PRESCALE(PRESCALE)) u_scan (
    .clk     (clk),
    .rst_n   (rst_int),
    .restart (mode_wr),
    .decoded (dec_q),
    .tick    (tick),
    .cnt     (cnt),
    .scan_o  (scan_o)
  );

  assign row_valid = !cnt[SCAN_W-1];
  assign digit     = dec_q ? {{(SCAN_W-DEC_W){1'b0}}, cnt[DEC_W-1:0]} : cnt;

  kbd_debounce #(.DEBOUNCE(DEBOUNCE)) u_deb (
    .clk       (clk),
    .rst_n     (rst_int),
    .restart   (mode_wr),
    .tick      (tick),
    .row_valid (row_valid),
    .row       (cnt[ROW_W-1:0]),
    .ret_i     (ret_i),
    .key_push  (key_push),
    .key_row   (key_row),
    .key_col   (key_col)
  );

  assign key_code = {ctrl_i, shift_i, key_row, key_col};

  kbd_key_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_int),
    .push    (key_push),
    .din     (key_code),
    .pop     (pop),
    .ovf_clr (ovf_clr),
    .dout    (head),
    .empty   (f_empty),
    .full    (f_full),
    .ovf     (f_ovf),
    .count   (f_count)
  );

  kbd_disp_ram #(.BYTE_W(8)) u_disp (
    .clk      (clk),
    .rst_n    (rst_int),
    .set_addr (addr_set),
    .addr_in  (host_wdata[SCAN_W-1:0]),
    .wr       (data_wr),
    .wdata    (host_wdata),
    .digit    (digit),
    .seg      (seg_o)
  );

  assign irq_o      = !f_empty;
  assign host_rdata = rdata_q;

  // R8: the interrupt only drops as a result of a host data read
  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_int)
    $fell(irq_o) |-> $past(host_rd && !host_cmd));

  // R12: read data holds between read strobes
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_int)
    !$past(host_rd) |-> $stable(host_rdata));
endmodule

// File: tb/kbd_scan_ctrl_tb.sv
module kbd_scan_ctrl_tb;
  localparam int PS  = 4;
  localparam int DEB = 200;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_cmd, host_wr, host_rd;
  logic [7:0] host_wdata, host_rdata;
  logic [7:0] ret_i;
  logic       shift_i, ctrl_i;
  logic [3:0] scan_o;
  logic [7:0] seg_o;
  logic       irq_o;

  logic [7:0] keys [8];
  logic       dec_mode;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  kbd_scan_ctrl #(.PRESCALE(PS), .DEBOUNCE(DEB), .FIFO_DEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_cmd(host_cmd), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ret_i(ret_i), .shift_i(shift_i), .ctrl_i(ctrl_i), .scan_o(scan_o),
    .seg_o(seg_o), .irq_o(irq_o)
  );

  // switch matrix model: the driven row returns its closed columns
  always_comb begin
    ret_i = '0;
    if (dec_mode) begin
      for (int r = 0; r < 4; r++) if (scan_o == 4'(1 << r)) ret_i = keys[r];
    end else if (!scan_o[3]) begin
      ret_i = keys[scan_o[2:0]];
    end
  end

  // {row, column mask, shift, ctrl, expected code}
  typedef struct packed {
    logic [2:0] row;
    logic [7:0] mask;
    logic       sh;
    logic       ct;
    logic [7:0] exp;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VT [NV] = '{
    '{3'd0, 8'h01, 1'b0, 1'b0, 8'h00},
    '{3'd2, 8'h20, 1'b1, 1'b0, 8'h55},
    '{3'd7, 8'h80, 1'b1, 1'b1, 8'hFF},
    '{3'd5, 8'h02, 1'b0, 1'b1, 8'hA9},
    '{3'd3, 8'h40, 1'b0, 1'b0, 8'h1E},
    '{3'd4, 8'h44, 1'b0, 1'b0, 8'h22}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_cmd = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic sel, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_cmd = sel;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_keys();
    for (int r = 0; r < 8; r++) keys[r] = '0;
  endtask

  task automatic press(input int row, input logic [7:0] mask, input int hold);
    keys[row] = mask;
    idle(hold);
    clear_keys();
    idle(150);
  endtask

  task automatic wait_scan(input logic [3:0] v, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (scan_o == v) begin ok = 1'b1; break; end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic [3:0] prev;
    bit         ok, seq_ok, per_ok;
    int         since;
    host_cmd = 0; host_wr = 0; host_rd = 0; host_wdata = 0;
    shift_i = 0; ctrl_i = 0; dec_mode = 0;
    clear_keys();
    rst_n = 1'b0;
    idle(5);
    // R13 reset state
    chk("R13 scan", {4'h0, scan_o}, 8'h00);
    chk("R13 irq", {7'h0, irq_o}, 8'h00);
    chk("R13 rdata", host_rdata, 8'h00);
    chk("R13 seg", seg_o, 8'h00);
    rst_n = 1'b1;
    idle(5);
    host_read(1'b1, d);
    chk("R13 status", d, 8'h00);

    // R1 binary count, step and period
    seq_ok = 1'b1; per_ok = 1'b1;
    prev = scan_o; since = 0;
    for (int n = 0; n < 20; ) begin
      @(negedge clk);
      since++;
      if (scan_o != prev) begin
        if (scan_o != prev + 4'd1) seq_ok = 1'b0;
        if (n > 0 && since != PS) per_ok = 1'b0;
        prev = scan_o; since = 0; n++;
      end
    end
    chk("R1 sequence", {7'h0, seq_ok}, 8'h01);
    chk("R1 period", {7'h0, per_ok}, 8'h01);

    // R3 R5 R7 R8 R12 table of key vectors
    for (int v = 0; v < NV; v++) begin
      shift_i = VT[v].sh; ctrl_i = VT[v].ct;
      keys[VT[v].row] = VT[v].mask;
      idle(500);
      chk("R8 irq while waiting", {7'h0, irq_o}, 8'h01);
      clear_keys();
      idle(150);
      host_read(1'b0, d);
      chk("R5 code byte", d, VT[v].exp);
      chk("R8 irq after last read", {7'h0, irq_o}, 8'h00);
    end
    shift_i = 0; ctrl_i = 0;

    // R4 bounce shorter than the debounce window
    press(6, 8'h08, 70);
    idle(300);
    host_read(1'b1, d);
    chk("R4 bounce stored nothing", d, 8'h00);

    // R6 long hold stores one code
    press(1, 8'h04, 1500);
    host_read(1'b1, d);
    chk("R6 one entry for held key", d, 8'h01);
    host_read(1'b0, d);
    chk("R6 held key code", d, 8'h0A);

    // R7 R9 fill beyond depth
    for (int r = 0; r < 8; r++) press(r, 8'h01, 500);
    press(0, 8'h02, 500);
    host_read(1'b1, d);
    chk("R9 status full with overflow", d, 8'hC8);
    for (int r = 0; r < 8; r++) begin
      host_read(1'b0, d);
      chk("R7 order", d, 8'(r << 3));
    end
    host_read(1'b0, d);
    chk("R12 empty read", d, 8'h00);
    host_read(1'b1, d);
    chk("R9 overflow sticky", d, 8'h80);
    host_write(1'b1, 8'h40);
    host_read(1'b1, d);
    chk("R9 overflow cleared", d, 8'h00);

    // R10 R11 display writes with wrap
    host_write(1'b1, 8'h8E);
    host_write(1'b0, 8'hA1);
    host_write(1'b0, 8'hB2);
    host_write(1'b0, 8'hC3);
    wait_scan(4'd14, ok);
    chk("R11 digit 14", ok ? seg_o : 8'hEE, 8'hA1);
    wait_scan(4'd15, ok);
    chk("R10 digit 15", ok ? seg_o : 8'hEE, 8'hB2);
    wait_scan(4'd0, ok);
    chk("R10 wrap to digit 0", ok ? seg_o : 8'hEE, 8'hC3);

    // R2 decoded mode
    host_write(1'b1, 8'h01);
    dec_mode = 1'b1;
    chk("R2 restart one-hot", {4'h0, scan_o}, 8'h01);
    chk("R11 decoded digit 0", seg_o, 8'hC3);
    seq_ok = 1'b1;
    prev = scan_o;
    for (int n = 0; n < 4; ) begin
      @(negedge clk);
      if (scan_o != prev) begin
        if (scan_o != {prev[2:0], prev[3]}) seq_ok = 1'b0;
        prev = scan_o; n++;
      end
    end
    chk("R2 one-hot rotation", {7'h0, seq_ok}, 8'h01);
    wait_scan(4'b0010, ok);
    chk("R11 decoded digit 1", ok ? seg_o : 8'hEE, 8'h00);

    // R3 decoded rows: row 1 reachable, row 5 never scanned
    press(1, 8'h08, 500);
    host_read(1'b0, d);
    chk("R3 decoded key", d, 8'h0B);
    press(5, 8'h01, 500);
    host_read(1'b1, d);
    chk("R3 row 5 not scanned in decoded", d, 8'h00);

    host_write(1'b1, 8'h00);
    dec_mode = 1'b0;
    idle(2);
    chk("R2 back to encoded", {4'h0, scan_o}, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule